// File: doc/BRIEF.md
# Debug Run/Step Clock Controller

This block sits between a debug command source and the clock generator of a 65xx-family processor. It decides, cycle by cycle, whether the processor receives a clock. With it a debug host can put the processor through a reset and leave it parked, let it run, stop it, or advance it by a counted number of bus cycles or whole instructions. It watches the processor's bus-status pins to find the opcode-fetch cycle that begins each instruction.

Until the first command arrives after the controller's own reset, the processor runs freely and the controller does not interfere. A reset command or a step is an operation that takes several cycles. It ends with a one-cycle done pulse and leaves the processor halted. While such an operation is in progress, any further command is dropped. A pin-compatible 8-bit variant is selected by a parameter. That variant takes its fetch indication from a single status pin, while the 16-bit variant requires two status pins to be high together.

Top module: `cpu_step_clkctl`

## Requirements
- R1: A reset command (cmd_op = 2'b00) drives cpu_reset high for exactly RST_CYCLES cycles, all with cpu_clk_en high. After that it releases cpu_reset, drops cpu_clk_en and pulses op_done, and the processor stays halted until the next command.
- R2: A run command (cmd_op = 2'b01) holds cpu_clk_en high on every cycle after the accepting edge, until another command changes it.
- R3: A stop command (cmd_op = 2'b11) drops cpu_clk_en from the cycle after the accepting edge and does not pulse op_done.
- R4: With WIDE_CPU = 1, an opcode fetch is a cycle in which st_prog and st_data are both high. A cycle with only one of them high is not a fetch. With WIDE_CPU = 0, st_fetch alone marks the fetch.
- R5: After the controller's reset and before any command, cpu_clk_en is high on every cycle, cpu_reset is low, and halted, busy and op_done are low.
- R6: A step command (cmd_op = 2'b10) with cmd_unit = 0 and cmd_count = N > 0 gives the processor exactly N enabled cycles. It then halts and pulses op_done.
- R7: A step command with cmd_unit = 1 and cmd_count = N > 0 lets the processor complete the remaining cycles of the current instruction uncounted, then execute N instructions. cpu_clk_en drops in the cycle that presents the next opcode fetch, which is therefore not executed.
- R8: A step command with cmd_count = 0 enables no cycle and pulses op_done on the cycle right after the accepting edge, in either unit.
- R9: While busy is high (a reset sequence or a step is in progress), every command is ignored. busy falls only together with an op_done pulse.
- R10: halted is high exactly when cpu_clk_en is low, and op_done is high for a single cycle per completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high controller reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 00 reset-halt, 01 run, 10 step, 11 stop |
| cmd_count | input | CNT_W | Step amount |
| cmd_unit | input | 1 | Step unit: 0 bus cycles, 1 instructions |
| st_fetch | input | 1 | Single-pin opcode-fetch status (8-bit variant) |
| st_prog | input | 1 | Program-address-valid status (16-bit variant) |
| st_data | input | 1 | Data-address-valid status (16-bit variant) |
| cpu_clk_en | output | 1 | Enable for the processor clock generator; the status pins describe the cycle it gates |
| cpu_reset | output | 1 | Reset to the processor, active high |
| halted | output | 1 | High while the processor clock is held off |
| op_done | output | 1 | One-cycle pulse when a reset sequence or step ends |
| busy | output | 1 | A reset sequence or step is in progress |

## Verification
A command accepted at edge k changes the mode at that edge. Run, stop and a zero-count step therefore show on cpu_clk_en and op_done in the cycle after k. A cycle step of N gives enabled cycles k+1 through k+N and pulses op_done one cycle later. An instruction step drops the enable combinationally in the cycle that presents the next fetch, and pulses op_done on the following cycle. The bench drives inputs and samples outputs on falling edges. For every reset or step it queues the expected enabled-cycle count and the final position of a cycle-accurate processor model; a monitor compares them when op_done is seen, and an unexpected pulse counts as a failure.

// File: rtl/cpu_step_clkctl_pkg.sv
package cpu_step_clkctl_pkg;

  // Command codes on cmd_op
  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_RUN   = 2'b01,
    OP_STEP  = 2'b10,
    OP_STOP  = 2'b11
  } cmd_op_e;

  // Controller modes
  typedef enum logic [2:0] {
    M_FREE   = 3'd0,   // no debug session: processor untouched
    M_RSTSEQ = 3'd1,   // processor reset being applied
    M_HALT   = 3'd2,   // parked
    M_RUN    = 3'd3,   // released by host
    M_STEP   = 3'd4    // counted advance in progress
  } ctl_mode_e;

  localparam logic UNIT_CYC  = 1'b0;
  localparam logic UNIT_INSN = 1'b1;

endpackage

// File: rtl/cpu_fetch_detect.sv
module cpu_fetch_detect #(
  parameter bit WIDE_CPU = 1'b1
) (
  input  logic st_fetch,
  input  logic st_prog,
  input  logic st_data,
  output logic is_fetch
);

  generate
    if (WIDE_CPU) begin : g_wide
      // opcode fetch: program and data address both flagged valid
      assign is_fetch = st_prog & st_data;
      logic unused_pin;
      assign unused_pin = st_fetch;
    end else begin : g_narrow
      assign is_fetch = st_fetch;
      logic unused_pins;
      assign unused_pins = st_prog ^ st_data;
    end
  endgenerate

endmodule

// File: rtl/cpu_step_counter.sv
module cpu_step_counter
  import cpu_step_clkctl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_unit,
  input  logic             active,
  input  logic             clk_en,
  input  logic             is_fetch,
  output logic             hold,
  output logic             finish
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain;
  logic             unit_q;
  logic             at_zero;
  logic             consume;

  assign at_zero = (remain == '0);

  // instruction unit: next fetch arrives with nothing left to run
  assign hold = active && (unit_q == UNIT_INSN) && is_fetch && at_zero;

  assign finish = active &&
                  ((unit_q == UNIT_INSN) ? (is_fetch && at_zero)
                                         : (clk_en && remain == ONE));

  assign consume = active && clk_en && !at_zero &&
                   ((unit_q == UNIT_CYC) || is_fetch);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      unit_q <= UNIT_CYC;
    end else if (load) begin
      remain <= load_val;
      unit_q <= load_unit;
    end else if (consume) begin
      remain <= remain - ONE;
    end
  end

endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  output logic last
);

  localparam int RW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [RW-1:0] LOAD = RW'(RST_CYCLES - 1);

  logic [RW-1:0] left;

  assign last = active && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (start) begin
      left <= LOAD;
    end else if (active && left != '0) begin
      left <= left - 1'b1;
    end
  end

endmodule

// File: rtl/cpu_step_clkctl.sv
module cpu_step_clkctl
  import cpu_step_clkctl_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 4,
  parameter bit WIDE_CPU   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_unit,
  input  logic             st_fetch,
  input  logic             st_prog,
  input  logic             st_data,
  output logic             cpu_clk_en,
  output logic             cpu_reset,
  output logic             halted,
  output logic             op_done,
  output logic             busy
);

  ctl_mode_e mode;
  cmd_op_e   op;
  logic      is_fetch;
  logic      accept;
  logic      zero_req;
  logic      step_load;
  logic      seq_start;
  logic      seq_active;
  logic      seq_last;
  logic      step_active;
  logic      step_hold;
  logic      step_finish;

  assign op          = cmd_op_e'(cmd_op);
  assign step_active = (mode == M_STEP);
  assign seq_active  = (mode == M_RSTSEQ);
  assign busy        = step_active || seq_active;
  assign accept      = cmd_valid && !busy;
  assign zero_req    = (cmd_count == '0);
  assign step_load   = accept && (op == OP_STEP) && !zero_req;
  assign seq_start   = accept && (op == OP_RESET);

  cpu_fetch_detect #(
    .WIDE_CPU (WIDE_CPU)
  ) u_fetch (
    .st_fetch (st_fetch),
    .st_prog  (st_prog),
    .st_data  (st_data),
    .is_fetch (is_fetch)
  );

  cpu_step_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .load      (step_load),
    .load_val  (cmd_count),
    .load_unit (cmd_unit),
    .active    (step_active),
    .clk_en    (cpu_clk_en),
    .is_fetch  (is_fetch),
    .hold      (step_hold),
    .finish    (step_finish)
  );

  cpu_reset_seq #(
    .RST_CYCLES (RST_CYCLES)
  ) u_rseq (
    .clk    (clk),
    .rst    (rst),
    .start  (seq_start),
    .active (seq_active),
    .last   (seq_last)
  );

  // Enable depends on the pending cycle type in instruction steps,
  // so it is decoded from the mode register and the status pins.
  always_comb begin
    unique case (mode)
      M_FREE, M_RUN, M_RSTSEQ: cpu_clk_en = 1'b1;
      M_STEP:                  cpu_clk_en = !step_hold;
      default:                 cpu_clk_en = 1'b0;
    endcase
  end

  assign halted = !cpu_clk_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_FREE;
      cpu_reset <= 1'b0;
      op_done   <= 1'b0;
    end else begin
      op_done <= 1'b0;
      unique case (mode)
        M_RSTSEQ: begin
          if (seq_last) begin
            mode      <= M_HALT;
            cpu_reset <= 1'b0;
            op_done   <= 1'b1;
          end
        end
        M_STEP: begin
          if (step_finish) begin
            mode    <= M_HALT;
            op_done <= 1'b1;
          end
        end
        default: begin
          if (accept) begin
            unique case (op)
              OP_RESET: begin
                mode      <= M_RSTSEQ;
                cpu_reset <= 1'b1;
              end
              OP_RUN:  mode <= M_RUN;
              OP_STOP: mode <= M_HALT;
              default: begin
                if (zero_req) begin
                  mode    <= M_HALT;
                  op_done <= 1'b1;
                end else begin
                  mode <= M_STEP;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cpu_step_clkctl_chk.sv
module cpu_step_clkctl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [CNT_W-1:0] cmd_count,
  input logic             cpu_clk_en,
  input logic             cpu_reset,
  input logic             op_done,
  input logic             busy
);

  logic seen_cmd;

  always_ff @(posedge clk) begin
    if (rst) seen_cmd <= 1'b0;
    else if (cmd_valid) seen_cmd <= 1'b1;
  end

  // R1
  reset_clocked_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_reset |-> cpu_clk_en);

  // R1
  reset_parks_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_reset) |-> (!cpu_clk_en && op_done));

  // R5
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_cmd |-> (cpu_clk_en && !cpu_reset && !busy));

  // R8
  zero_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'b10 && cmd_count == '0)
      |=> (op_done && !cpu_clk_en));

  // R9
  busy_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || op_done));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

endmodule

bind cpu_step_clkctl cpu_step_clkctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_count  (cmd_count),
  .cpu_clk_en (cpu_clk_en),
  .cpu_reset  (cpu_reset),
  .op_done    (op_done),
  .busy       (busy)
);

// File: tb/cpu_step_clkctl_bench.sv
module cpu_step_clkctl_bench;

  localparam int CW = 16;
  localparam int RC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [CW-1:0] cmd_count = '0;
  logic          cmd_unit = 1'b0;
  logic          st_fetch, st_prog, st_data;
  logic          cpu_clk_en, cpu_reset, halted, op_done, busy;

  always #5 clk = ~clk;

  cpu_step_clkctl #(.CNT_W(CW), .RST_CYCLES(RC), .WIDE_CPU(1'b1)) u_cpu_step_clkctl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_unit(cmd_unit), .st_fetch(st_fetch),
    .st_prog(st_prog), .st_data(st_data), .cpu_clk_en(cpu_clk_en),
    .cpu_reset(cpu_reset), .halted(halted), .op_done(op_done), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- processor model ----------------
  int m_idx = 0;
  int m_cyc = 0;
  int en_total = 0;
  int rst_hi = 0;

  function automatic int ilen(input int i);
    return 2 + (i % 4);
  endfunction

  // non-fetch cycles raise only one of the two status pins (R4)
  assign st_fetch = (m_cyc == 0);
  assign st_prog  = (m_cyc == 0) || (m_cyc % 2 == 1);
  assign st_data  = (m_cyc == 0) || (m_cyc % 2 == 0);

  always @(posedge clk) begin
    if (rst) begin
      m_idx <= 0;
      m_cyc <= 0;
    end else if (cpu_clk_en) begin
      en_total <= en_total + 1;
      if (cpu_reset) begin
        m_idx <= 0;
        m_cyc <= 0;
      end else if (m_cyc == ilen(m_idx) - 1) begin
        m_idx <= m_idx + 1;
        m_cyc <= 0;
      end else begin
        m_cyc <= m_cyc + 1;
      end
    end
  end

  always @(negedge clk) if (!rst && cpu_reset) rst_hi++;

  // ---------------- checking ----------------
  task automatic chk_eq(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // scoreboard
  string q_req[$];
  bit    q_cc[$];
  int    q_cycles[$];
  int    q_base[$];
  int    q_idx[$];
  int    q_cyc[$];

  always @(negedge clk) begin
    if (!rst && op_done) begin
      if (q_req.size() == 0) begin
        chk_eq("R9 unexpected op_done", 1, 0);
      end else begin
        string r;
        bit cc;
        int ec, b, ei, ey;
        r  = q_req.pop_front();
        cc = q_cc.pop_front();
        ec = q_cycles.pop_front();
        b  = q_base.pop_front();
        ei = q_idx.pop_front();
        ey = q_cyc.pop_front();
        if (cc) chk_eq({r, " enabled cycles"}, en_total - b, ec);
        chk_eq({r, " instruction index"}, m_idx, ei);
        chk_eq({r, " cycle in instruction"}, m_cyc, ey);
        chk_eq({r, " R10 halted at done"}, int'(halted), 1);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic adv(inout int i, inout int c);
    if (c == ilen(i) - 1) begin
      i++;
      c = 0;
    end else begin
      c++;
    end
  endtask

  task automatic send(input logic [1:0] op, input int n, input logic unit);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_count = CW'(n);
    cmd_unit  = unit;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!op_done) @(negedge clk);
    @(negedge clk);
    chk_eq("R10 op_done single cycle", int'(op_done), 0);
  endtask

  task automatic step_exp(input string req, input int n, input logic unit);
    int i, c, cycles, fetches;
    i = m_idx;
    c = m_cyc;
    cycles = 0;
    fetches = 0;
    if (n != 0) begin
      if (unit) begin
        while (!(c == 0 && fetches == n)) begin
          if (c == 0) fetches++;
          adv(i, c);
          cycles++;
        end
      end else begin
        repeat (n) begin
          adv(i, c);
          cycles++;
        end
      end
    end
    q_req.push_back(req);
    q_cc.push_back(1'b1);
    q_cycles.push_back(cycles);
    q_base.push_back(en_total);
    q_idx.push_back(i);
    q_cyc.push_back(c);
    send(2'b10, n, unit);
  endtask

  bit finished = 1'b0;

  initial begin
    int b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5 reset state and free running
    chk_eq("R5 cpu_clk_en after reset", int'(cpu_clk_en), 1);
    chk_eq("R5 cpu_reset after reset", int'(cpu_reset), 0);
    chk_eq("R5 halted after reset", int'(halted), 0);
    chk_eq("R5 busy after reset", int'(busy), 0);
    chk_eq("R5 op_done after reset", int'(op_done), 0);
    b = en_total;
    repeat (10) @(negedge clk);
    chk_eq("R5 free-run cycles", en_total - b, 10);

    // R1 reset-and-halt
    q_req.push_back("R1 reset-halt");
    q_cc.push_back(1'b0);
    q_cycles.push_back(0);
    q_base.push_back(0);
    q_idx.push_back(0);
    q_cyc.push_back(0);
    rst_hi = 0;
    send(2'b00, 0, 1'b0);
    wait_done();
    chk_eq("R1 cpu_reset high cycles", rst_hi, RC);
    chk_eq("R1 clock held off after reset", int'(cpu_clk_en), 0);
    b = en_total;
    repeat (6) @(negedge clk);
    chk_eq("R1 stays halted", en_total - b, 0);
    chk_eq("R10 halted while enable low", int'(halted), 1);

    // R7 R4 instruction step from a fetch
    step_exp("R7 R4 instr step 3", 3, 1'b1);
    wait_done();
    // R6 cycle step stopping mid-instruction
    step_exp("R6 cycle step 4", 4, 1'b0);
    wait_done();
    // R7 instruction step starting mid-instruction
    step_exp("R7 instr step 2 from mid", 2, 1'b1);
    wait_done();
    // R8 zero counts in both units
    step_exp("R8 zero instr step", 0, 1'b1);
    wait_done();
    step_exp("R8 zero cycle step", 0, 1'b0);
    wait_done();
    // R6 single cycle
    step_exp("R6 cycle step 1", 1, 1'b0);
    wait_done();

    // R9 commands during a step are dropped
    step_exp("R9 cycle step 20", 20, 1'b0);
    repeat (3) @(negedge clk);
    send(2'b01, 0, 1'b0);
    send(2'b10, 5, 1'b0);
    send(2'b00, 0, 1'b0);
    wait_done();
    b = en_total;
    repeat (8) @(negedge clk);
    chk_eq("R9 no run after ignored command", en_total - b, 0);
    chk_eq("R9 no reset after ignored command", int'(cpu_reset), 0);

    // R2 run
    send(2'b01, 0, 1'b0);
    chk_eq("R2 enable after run", int'(cpu_clk_en), 1);
    chk_eq("R10 halted low while running", int'(halted), 0);
    b = en_total;
    repeat (10) @(negedge clk);
    chk_eq("R2 run cycles", en_total - b, 10);

    // R3 stop
    send(2'b11, 0, 1'b0);
    chk_eq("R3 enable after stop", int'(cpu_clk_en), 0);
    chk_eq("R3 no done on stop", int'(op_done), 0);
    b = en_total;
    repeat (4) @(negedge clk);
    chk_eq("R3 stays stopped", en_total - b, 0);

    // R7 after stop at an arbitrary point
    step_exp("R7 instr step 1 after stop", 1, 1'b1);
    wait_done();
    step_exp("R7 R4 instr step 5", 5, 1'b1);
    wait_done();

    repeat (3) @(negedge clk);
    chk_eq("R9 scoreboard drained", q_req.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule